// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

This block is a software watchdog. It counts ticks of a reference clock enable and raises a reset request if software does not service it within a chosen timeout. The timeout is one of eight power-of-two tick counts. A range bit and a 2-bit step field pick the count. Software services the timer by writing a two-byte key to a byte-wide service port. The key is 0x55 followed by 0xAA, and it restarts the count.

A new timeout selection is not applied at once. It is captured only when a full key sequence completes, so a stray write to the selection pins cannot shorten or lengthen a timeout that is already running. When a timeout expires, the block gives a one-clock reset request and sets a sticky flag that stays set until system reset. While the watchdog is disabled, the counter and the key state are held clear.

Top module: `keyed_watchdog`

## Requirements
- R1: After system reset, `resetReq` and `timeoutFlag` are 0, the counter is 0 and the applied selection is range 0 / step 00. The first timeout therefore comes 512 ticks after the watchdog is enabled.
- R2: With the applied range bit at 0, step values 00, 01, 10 and 11 give timeouts of 2^9, 2^11, 2^13 and 2^15 ticks.
- R3: With the applied range bit at 1, step values 00, 01, 10 and 11 give timeouts of 2^18, 2^20, 2^22 and 2^24 ticks.
- R4: A tick that finds the counter at the timeout count minus one raises `resetReq` high for exactly one clock, from the following clock edge. The counter restarts from 0. With a tick on every clock, pulses are spaced exactly one timeout apart.
- R5: `timeoutFlag` goes to 1 together with the first `resetReq` pulse and stays 1 until system reset. Disabling the watchdog does not clear it.
- R6: The counter advances only in clocks where `tickEn` is 1. With a tick on every second clock, the spacing between pulses doubles.
- R7: A write of 0x55 followed directly by a write of 0xAA completes a service and restarts the count from 0. Servicing more often than the timeout prevents every pulse.
- R8: A 0xAA write that does not directly follow a 0x55 write is ignored. Any other value written after 0x55 cancels the armed state. A repeated 0x55 keeps the sequence armed. Only service writes count; clocks with no write leave the key state unchanged.
- R9: Changes on `rangeSel` or `stepSel` have no effect until a service sequence completes. At that point the values present on the pins in the clock of the 0xAA write become the applied selection.
- R10: While `wdEnable` is 0, the counter and the key state are held clear, service writes are ignored and `resetReq` stays 0.
- R11: When a completing 0xAA write and a terminal tick fall in the same clock, the service wins. No pulse is produced and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| tickEn | input | 1 | Reference clock enable; one count per clock it is high |
| wdEnable | input | 1 | Watchdog enable |
| rangeSel | input | 1 | Selects the short (0) or long (1) range of timeouts |
| stepSel | input | 2 | Selects one of four timeouts within the range |
| svcWrite | input | 1 | Service register write strobe |
| svcData | input | 8 | Service register write data |
| resetReq | output | 1 | One-clock reset request on timeout |
| timeoutFlag | output | 1 | Sticky flag set by the first timeout |

## Verification
On every cycle, the in-line assertions check four things. The request is a single-clock pulse. The flag never falls. The counter stays below the applied limit and holds in clocks without a tick. The key state and the applied selection move only on the strobes that allow them.

Some behaviours can only be shown by the bench scenarios, which run against a behavioural model:
- the exact spacing between pulses for the selectable timeouts;
- selection changes being deferred until a service completes;
- which broken, cancelled or interleaved key sequences do or do not restart the count;
- the outcome when a service lands on the terminal tick.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  // Service key bytes, in the order they must be written.
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // Strobes from control to datapath; at most one of advance/clearCnt acts.
  typedef struct packed {
    logic advance;   // count one tick
    logic clearCnt;  // force the counter to zero
    logic latchSel;  // capture the pending timeout selection
    logic fire;      // timeout reached: pulse and set the sticky flag
  } wdStrobes_t;

endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tickEn,
  input  logic       svcWrite,
  input  logic [7:0] svcData,
  input  logic       atTerminal,
  output wdStrobes_t strobes
);

  typedef enum logic {KEY_IDLE, KEY_ARMED} keyState_t;

  keyState_t keyState, keyNext;
  logic      svcDone;
  logic      isFirst;
  logic      isSecond;

  assign isFirst  = (svcData == KEY_FIRST);
  assign isSecond = (svcData == KEY_SECOND);

  // A service completes only on a second key directly after an armed first key.
  assign svcDone = enable && svcWrite && (keyState == KEY_ARMED) && isSecond;

  always_comb begin
    keyNext = keyState;
    if (!enable) begin
      keyNext = KEY_IDLE;
    end else if (svcWrite) begin
      keyNext = isFirst ? KEY_ARMED : KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KEY_IDLE;
    else       keyState <= keyNext;
  end

  // Service outranks a terminal tick in the same clock.
  always_comb begin
    strobes.fire     = enable && tickEn && atTerminal && !svcDone;
    strobes.advance  = enable && tickEn && !atTerminal && !svcDone;
    strobes.latchSel = svcDone;
    strobes.clearCnt = !enable || svcDone || strobes.fire;
  end

  assert_disable_clears_key_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> keyState == KEY_IDLE);

  assert_first_key_arms_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && svcWrite && svcData == KEY_FIRST) |=> keyState == KEY_ARMED);

  assert_other_write_disarms_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && svcWrite && svcData != KEY_FIRST) |=> keyState == KEY_IDLE);

  assert_key_holds_without_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !svcWrite) |=> $stable(keyState));

endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int SHORT_EXP = 9,
  parameter int LONG_EXP  = 18,
  parameter int EXP_STEP  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdStrobes_t strobes,
  input  logic       rangeSel,
  input  logic [1:0] stepSel,
  output logic       atTerminal,
  output logic       resetReq,
  output logic       timeoutFlag
);

  localparam int SEL_W   = 3;
  localparam int N_SEL   = 1 << SEL_W;
  localparam int MAX_EXP = LONG_EXP + EXP_STEP * 3;

  initial begin
    if (MAX_EXP > CNT_W) $error("counter too narrow for the longest timeout");
  end

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] selApplied;
  logic [CNT_W-1:0] termTable [N_SEL];
  logic [CNT_W-1:0] termValue;

  // Terminal value (divide count minus one) for each selection code.
  for (genvar g = 0; g < N_SEL; g++) begin : gTerm
    localparam int E = ((g >= 4) ? LONG_EXP : SHORT_EXP) + EXP_STEP * (g % 4);
    assign termTable[g] = {CNT_W{1'b1}} >> (CNT_W - E);
  end

  assign termValue  = termTable[selApplied];
  assign atTerminal = (cnt == termValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobes.clearCnt) cnt <= '0;
    else if (strobes.advance)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 selApplied <= '0;
    else if (strobes.latchSel) selApplied <= {rangeSel, stepSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq    <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      resetReq    <= strobes.fire;
      timeoutFlag <= timeoutFlag | strobes.fire;
    end
  end

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_restart_after_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> cnt == '0);

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termValue);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |=> timeoutFlag);

  assert_count_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.clearCnt) |=> $stable(cnt));

  assert_sel_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchSel |=> $stable(selApplied));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int SHORT_EXP = 9,
  parameter int LONG_EXP  = 18,
  parameter int EXP_STEP  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wdEnable,
  input  logic       rangeSel,
  input  logic [1:0] stepSel,
  input  logic       svcWrite,
  input  logic [7:0] svcData,
  output logic       resetReq,
  output logic       timeoutFlag
);

  wdStrobes_t strobes;
  logic       atTerminal;

  kwd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (wdEnable),
    .tickEn     (tickEn),
    .svcWrite   (svcWrite),
    .svcData    (svcData),
    .atTerminal (atTerminal),
    .strobes    (strobes)
  );

  kwd_datapath #(
    .CNT_W     (CNT_W),
    .SHORT_EXP (SHORT_EXP),
    .LONG_EXP  (LONG_EXP),
    .EXP_STEP  (EXP_STEP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rangeSel    (rangeSel),
    .stepSel     (stepSel),
    .atTerminal  (atTerminal),
    .resetReq    (resetReq),
    .timeoutFlag (timeoutFlag)
  );

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> !resetReq);

endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       wdEnable = 1'b0;
  logic       rangeSel = 1'b0;
  logic [1:0] stepSel = 2'b00;
  logic       svcWrite = 1'b0;
  logic [7:0] svcData = 8'h00;
  logic       resetReq;
  logic       timeoutFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wdEnable(wdEnable),
    .rangeSel(rangeSel), .stepSel(stepSel), .svcWrite(svcWrite),
    .svcData(svcData), .resetReq(resetReq), .timeoutFlag(timeoutFlag)
  );

  // Behavioural reference model, updated on every rising edge.
  longint mCnt = 0;
  int     mExp = 9;
  bit     mArmed = 0;
  bit     mRst = 0;
  bit     mFlag = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mExp = 9; mArmed = 0; mRst = 0; mFlag = 0;
    end else if (!wdEnable) begin
      mCnt = 0; mArmed = 0; mRst = 0;
    end else begin
      bit doneNow;
      bit fireNow;
      doneNow = svcWrite && mArmed && (svcData == 8'hAA);
      fireNow = tickEn && (mCnt == (longint'(1) << mExp) - 1) && !doneNow;
      mRst = fireNow;
      if (fireNow) mFlag = 1;
      if (doneNow) begin
        mCnt = 0;
        mExp = (rangeSel ? 18 : 9) + 2 * int'(stepSel);
      end else if (fireNow) begin
        mCnt = 0;
      end else if (tickEn) begin
        mCnt = mCnt + 1;
      end
      if (svcWrite) mArmed = (svcData == 8'h55);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(resetReq === mRst, "R4 resetReq vs model", resetReq, mRst);
      check(timeoutFlag === mFlag, "R5 timeoutFlag vs model", timeoutFlag, mFlag);
    end
  end

  task automatic svcWr(input logic [7:0] d);
    @(negedge clk); svcWrite = 1'b1; svcData = d;
    @(negedge clk); svcWrite = 1'b0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!resetReq && n < 20000);
  endtask

  task automatic countPulses(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (resetReq) pulses++;
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual %0d cycles expected completion", WATCHDOG_CYCLES);
    summary();
  end

  initial begin
    int g;
    int p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs cleared after reset
    check(resetReq == 0, "R1 resetReq after reset", resetReq, 0);
    check(timeoutFlag == 0, "R1 timeoutFlag after reset", timeoutFlag, 0);

    // R1: default selection gives the first pulse 512 ticks after enable
    wdEnable = 1'b1;
    waitPulse(g);
    check(g == 512, "R1 first timeout after enable", g, 512);
    // R2/R4: pulse spacing at step 00
    waitPulse(g);
    check(g == 512, "R2 spacing for 2^9", g, 512);
    @(negedge clk);
    check(resetReq == 0, "R4 pulse lasts one clock", resetReq, 0);
    check(timeoutFlag == 1, "R5 flag set after timeout", timeoutFlag, 1);

    // R6: tick every second clock doubles spacing
    fork
      begin : tickGen
        forever begin @(negedge clk); tickEn = ~tickEn; end
      end
      begin
        waitPulse(g); waitPulse(g);
      end
    join_any
    disable tickGen;
    @(negedge clk); tickEn = 1'b1;
    check(g == 1024, "R6 spacing with half-rate tick", g, 1024);

    // R9: selection change without service has no effect
    waitPulse(g);
    stepSel = 2'b01;
    waitPulse(g);
    check(g == 512, "R9 pending selection not applied", g, 512);
    svcWr(8'h55); svcWr(8'hAA);
    waitPulse(g); waitPulse(g);
    check(g == 2048, "R2 spacing for 2^11 after service", g, 2048);

    // back to the shortest timeout
    stepSel = 2'b00;
    svcWr(8'h55); svcWr(8'hAA);
    waitPulse(g);

    // R7: periodic servicing prevents every pulse
    p = 0;
    for (int k = 0; k < 8; k++) begin
      int q;
      countPulses(400, q);
      p += q;
      svcWr(8'h55); svcWr(8'hAA);
    end
    check(p == 0, "R7 no pulse while serviced", p, 0);

    // R8: lone 0xAA ignored
    waitPulse(g);
    repeat (100) @(negedge clk);
    svcWr(8'hAA);
    waitPulse(g);
    check(100 + 2 + g == 512, "R8 lone second key ignored", 102 + g, 512);
    // R8: other value after 0x55 cancels
    repeat (100) @(negedge clk);
    svcWr(8'h55); svcWr(8'h12); svcWr(8'hAA);
    waitPulse(g);
    check(100 + 6 + g == 512, "R8 cancelled sequence ignored", 106 + g, 512);
    // R8: repeated 0x55 stays armed
    repeat (100) @(negedge clk);
    svcWr(8'h55); svcWr(8'h55); svcWr(8'hAA);
    waitPulse(g);
    check(100 + 6 + g > 512, "R8 repeated first key still services", 106 + g, 513);

    // R11: service on the terminal tick wins
    waitPulse(g);
    repeat (510) @(negedge clk);
    svcWrite = 1'b1; svcData = 8'h55;
    @(negedge clk); svcData = 8'hAA;
    @(negedge clk); svcWrite = 1'b0;
    check(resetReq == 0, "R11 no pulse when service meets terminal", resetReq, 0);
    waitPulse(g);
    check(g == 512, "R11 count restarted by service", g, 512);

    // R3: long range, no pulse within a short window
    rangeSel = 1'b1;
    svcWr(8'h55); svcWr(8'hAA);
    countPulses(5000, p);
    check(p == 0, "R3 long range 2^18 not reached", p, 0);
    rangeSel = 1'b0;
    svcWr(8'h55); svcWr(8'hAA);
    waitPulse(g); waitPulse(g);
    check(g == 512, "R2 short range restored", g, 512);

    // R10: disabled watchdog is quiet and forgets the armed key
    wdEnable = 1'b0;
    countPulses(2000, p);
    check(p == 0, "R10 no pulse while disabled", p, 0);
    check(timeoutFlag == 1, "R5 flag survives disable", timeoutFlag, 1);
    wdEnable = 1'b1;
    svcWr(8'h55);
    wdEnable = 1'b0;
    @(negedge clk);
    wdEnable = 1'b1;
    svcWr(8'hAA);
    waitPulse(g);
    check(2 + g == 512, "R10 key state cleared by disable", 2 + g, 512);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule